// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block holds the 256-byte internal scratch store of an 8-bit controller core and decides where each data access lands. The byte address space is split at 80H. Below that line every access reaches the lower RAM bank, whatever the addressing mode. At and above 80H two separate storages answer to the same address: the upper RAM bank and the special-function-register space. The special-function registers live outside this block and are reached over a small bus port. The addressing mode of the access selects between them. A direct access goes out on the register bus. An indirect access stays in upper RAM.

A stack-pointer helper is built in. A push moves the pointer up by one and then stores the write byte at the new location. A pop returns the byte under the pointer and then moves the pointer down. Stack traffic always counts as indirect, so the stack can grow into upper RAM without ever touching a special-function register. Read results from both RAM and the register bus appear on one shared output, one clock after the read strobe.

Top module: `idm_top`

## Requirements
- R1: After synchronous reset the stack pointer output reads 07H and the read-data output reads 00H.
- R2: An access with address 00H–7FH reaches the lower RAM in both direct and indirect mode and never raises the register-bus read or write strobe.
- R3: A direct-mode write (acc_indirect=0) to an address 80H–FFH raises sfr_wr in the same cycle, with sfr_addr equal to the access address and sfr_wdata equal to the write byte.
- R4: An indirect-mode access (acc_indirect=1) to an address 80H–FFH reaches the upper RAM. The register-bus strobes stay low, and the register at that address is left unchanged.
- R5: Read data is registered. The byte for a read issued in cycle N is on rdata after the clock edge that ends cycle N. It stays there until the next read.
- R6: A push increments the stack pointer and writes acc_wdata to the new pointer address. The pointer output shows the new value after that edge. When push and pop are both asserted, push wins and pop is ignored.
- R7: A pop reads the byte at the current pointer, returns it with the same one-cycle latency as R5, and decrements the pointer.
- R8: The stack pointer wraps modulo 256: a push at FFH moves it to 00H, and a pop at 00H moves it to FFH.
- R9: A push or pop whose pointer address is 80H or above reaches the upper RAM and never raises a register-bus strobe.
- R10: Upper RAM and the register space at the same address are distinct. After a direct write and an indirect write to one address, a direct read returns the register byte and an indirect read returns the RAM byte.
- R11: A read whose target is the register space puts sfr_rdata on rdata one cycle after sfr_rd, using the same latency as RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | Byte address of a normal access |
| acc_wdata | input | 8 | Write byte for normal writes and pushes |
| acc_rd | input | 1 | Normal read strobe |
| acc_wr | input | 1 | Normal write strobe |
| acc_indirect | input | 1 | 1 = indirect addressing, 0 = direct addressing |
| stk_push | input | 1 | Push strobe |
| stk_pop | input | 1 | Pop strobe |
| rdata | output | 8 | Registered read data |
| sp_value | output | 8 | Current stack pointer |
| sfr_addr | output | 8 | Register-bus address |
| sfr_wdata | output | 8 | Register-bus write byte |
| sfr_rd | output | 1 | Register-bus read strobe |
| sfr_wr | output | 1 | Register-bus write strobe |
| sfr_rdata | input | 8 | Register-bus read byte, valid the cycle after sfr_rd |

## Verification
The assertions assume that at most one of acc_rd, acc_wr, stk_push and stk_pop is high in a cycle, except for the push-with-pop case that R6 defines. They also assume that the register-bus peripheral holds its returned byte until its next read. The stimulus tasks drive one operation per cycle from the falling edge and clear every strobe they do not use. The bench's register model updates its read register only on sfr_rd. That keeps the design inside both assumptions.

// File: rtl/idm_pkg.sv
// Package: shared types for the dual-space internal data memory.
// Assumes: nothing beyond IEEE 1800-2017.
package idm_pkg;
    // Destination of one access after address/mode steering.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LOW  = 2'd1,
        TGT_HIGH = 2'd2,
        TGT_SFR  = 2'd3
    } idm_tgt_e;
endpackage

// File: rtl/idm_steer.sv
// Module: idm_steer
// Decides whether an access lands in lower RAM, upper RAM or the
// special-function-register space. Assumes the caller has already
// folded stack traffic into indirect mode.
module idm_steer
    import idm_pkg::*;
(
    input  logic     active,
    input  logic     upper_half,
    input  logic     indirect,
    output idm_tgt_e tgt
);
    // Purpose: pick the target from the address half and the mode.
    always_comb begin
        if (!active)
            tgt = TGT_NONE;
        else if (!upper_half)
            tgt = TGT_LOW;
        else if (indirect)
            tgt = TGT_HIGH;
        else
            tgt = TGT_SFR;
    end
endmodule

// File: rtl/idm_stack_ptr.sv
// Module: idm_stack_ptr
// Holds the stack pointer. Push pre-increments and pop post-decrements,
// both wrapping at the pointer width. Assumes push has priority over pop.
module idm_stack_ptr #(
    parameter int           ADDR_W   = 8,
    parameter logic [7:0]   SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] sp_inc
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Purpose: next-up address used as the push destination.
    assign sp_inc = sp_q + ONE;

    // Purpose: pointer register with wrap-around update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= ADDR_W'(SP_RESET);
        else if (push)
            sp_q <= sp_inc;
        else if (pop)
            sp_q <= sp_q - ONE;
    end

    // R6
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp_q == $past(sp_q) + ONE);

    // R7
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp_q == $past(sp_q) - ONE);
endmodule

// File: rtl/idm_ram_bank.sv
// Module: idm_ram_bank
// One half of the internal RAM: single port, synchronous write, registered
// read that holds its value until the next read. Assumes wr_en and rd_en are
// never high together.
module idm_ram_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: store the write byte.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wdata;
    end

    // Purpose: registered read port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/idm_top.sv
// Module: idm_top
// Internal data memory with two storages behind addresses 80H-FFH: upper RAM
// for indirect and stack accesses, and the external special-function-register
// bus for direct accesses. Assumes one strobe per cycle (push may coincide
// with pop, push wins) and a register peripheral that returns its byte one
// cycle after sfr_rd and holds it until the next read.
module idm_top
    import idm_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_indirect,
    input  logic              stk_push,
    input  logic              stk_pop,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sp_value,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    output logic              sfr_rd,
    output logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int BANK_AW   = ADDR_W - 1;
    localparam int NUM_BANKS = 2;

    logic              stack_op;
    logic              pop_eff;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_inc;
    logic [ADDR_W-1:0] eff_addr;
    logic              eff_ind;
    logic              eff_rd;
    logic              eff_wr;
    idm_tgt_e          tgt;
    idm_tgt_e          src_q;
    logic [DATA_W-1:0] bank_q [NUM_BANKS];

    // Purpose: fold stack traffic and normal accesses into one access.
    always_comb begin
        stack_op = stk_push | stk_pop;
        pop_eff  = stk_pop & ~stk_push;
        eff_ind  = stack_op | acc_indirect;
        eff_wr   = stk_push | (acc_wr & ~stack_op);
        eff_rd   = pop_eff  | (acc_rd & ~stack_op);
        if (stk_push)
            eff_addr = sp_inc;
        else if (stk_pop)
            eff_addr = sp_q;
        else
            eff_addr = acc_addr;
    end

    idm_stack_ptr #(
        .ADDR_W  (ADDR_W),
        .SP_RESET(SP_RESET)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (pop_eff),
        .sp_q  (sp_q),
        .sp_inc(sp_inc)
    );

    idm_steer u_steer (
        .active    (eff_rd | eff_wr),
        .upper_half(eff_addr[ADDR_W-1]),
        .indirect  (eff_ind),
        .tgt       (tgt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        // Purpose: this bank is the target of the current access.
        assign hit = (b == 0) ? (tgt == TGT_LOW) : (tgt == TGT_HIGH);

        idm_ram_bank #(
            .AW(BANK_AW),
            .DW(DATA_W)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(eff_wr & hit),
            .rd_en(eff_rd & hit),
            .addr (eff_addr[BANK_AW-1:0]),
            .wdata(acc_wdata),
            .rdata(bank_q[b])
        );
    end

    // Purpose: drive the special-function-register bus.
    always_comb begin
        sfr_addr  = eff_addr;
        sfr_wdata = acc_wdata;
        sfr_rd    = eff_rd & (tgt == TGT_SFR);
        sfr_wr    = eff_wr & (tgt == TGT_SFR);
    end

    // Purpose: remember which storage answered the last read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= TGT_LOW;
        else if (eff_rd)
            src_q <= tgt;
    end

    // Purpose: shared read-data mux.
    always_comb begin
        if (src_q == TGT_SFR)
            rdata = sfr_rdata;
        else if (src_q == TGT_HIGH)
            rdata = bank_q[1];
        else
            rdata = bank_q[0];
    end

    assign sp_value = sp_q;

    // R2
    low_half_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_addr[ADDR_W-1] |-> !sfr_rd && !sfr_wr);

    // R3
    direct_wr_to_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !stack_op && !acc_indirect && acc_addr[ADDR_W-1])
        |-> sfr_wr && sfr_addr == acc_addr && sfr_wdata == acc_wdata);

    // R4
    indirect_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_indirect && (acc_rd || acc_wr)) |-> !sfr_rd && !sfr_wr);

    // R9
    stack_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_op |-> !sfr_rd && !sfr_wr);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(eff_rd) && src_q != TGT_SFR) |-> $stable(rdata));
endmodule

// File: tb/idm_top_tb_top.sv
// Bench: scoreboard around idm_top. Driver tasks queue the expected read
// bytes; a monitor on the falling edge pops and compares them against rdata.
module idm_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic       acc_indirect = 1'b0;
    logic       stk_push = 1'b0;
    logic       stk_pop = 1'b0;
    logic [7:0] rdata;
    logic [7:0] sp_value;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic       sfr_rd;
    logic       sfr_wr;
    logic [7:0] sfr_rdata;

    int checks = 0;
    int errors = 0;
    int sfr_wr_cnt = 0;
    int sfr_rd_cnt = 0;

    logic [7:0] sfr_mem [256];
    logic [7:0] ref_ram [256];
    logic [7:0] ref_sp;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    idm_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_indirect(acc_indirect),
        .stk_push(stk_push), .stk_pop(stk_pop), .rdata(rdata),
        .sp_value(sp_value), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_rdata(sfr_rdata)
    );

    // Register-bus peripheral model: one-cycle read, holds until next read.
    always @(posedge clk) begin
        if (sfr_wr) begin
            sfr_mem[sfr_addr] <= sfr_wdata;
            sfr_wr_cnt <= sfr_wr_cnt + 1;
        end
        if (sfr_rd) begin
            sfr_rdata  <= sfr_mem[sfr_addr];
            sfr_rd_cnt <= sfr_rd_cnt + 1;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare queued read bytes one cycle after the read edge.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic drive(logic [7:0] a, logic [7:0] d, logic rd, logic wr,
                         logic ind, logic pu, logic po);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_rd = rd; acc_wr = wr;
        acc_indirect = ind; stk_push = pu; stk_pop = po;
        @(posedge clk);
    endtask

    task automatic idle();
        drive(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic acc_write(logic [7:0] a, logic [7:0] d, logic ind);
        drive(a, d, 1'b0, 1'b1, ind, 1'b0, 1'b0);
        if (!a[7] || ind) ref_ram[a] = d;
    endtask

    task automatic acc_read(logic [7:0] a, logic ind, logic [7:0] exp, string tag);
        drive(a, 8'h00, 1'b1, 1'b0, ind, 1'b0, 1'b0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic push(logic [7:0] d, logic with_pop);
        drive(8'h00, d, 1'b0, 1'b0, 1'b0, 1'b1, with_pop);
        ref_sp = ref_sp + 8'd1;
        ref_ram[ref_sp] = d;
    endtask

    task automatic pop(string tag);
        drive(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        exp_q.push_back(ref_ram[ref_sp]);
        tag_q.push_back(tag);
        ref_sp = ref_sp - 8'd1;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        int r0;
        for (int i = 0; i < 256; i++) sfr_mem[i] = 8'(i) ^ 8'h5C;
        ref_sp = 8'h07;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 sp", sp_value, 8'h07);
        check("R1 rdata", rdata, 8'h00);

        // R2: lower half in both modes, no bus strobes
        acc_write(8'h10, 8'hA5, 1'b0);
        acc_write(8'h20, 8'h5A, 1'b1);
        acc_read(8'h10, 1'b1, 8'hA5, "R2 lower indirect read");
        acc_read(8'h20, 1'b0, 8'h5A, "R2 lower direct read");
        idle(); #1;
        check_int("R2 bus writes", sfr_wr_cnt, 0);
        check_int("R2 bus reads", sfr_rd_cnt, 0);

        // R3: direct write above 7FH reaches the register bus
        acc_write(8'hA0, 8'h33, 1'b0);
        #1;
        check_int("R3 bus write count", sfr_wr_cnt, 1);
        check("R3 register stored", sfr_mem[8'hA0], 8'h33);

        // R4: indirect write to A0H lands in RAM, register untouched
        acc_write(8'hA0, 8'hC4, 1'b1);
        #1;
        check_int("R4 bus write count", sfr_wr_cnt, 1);
        check("R4 register unchanged", sfr_mem[8'hA0], 8'h33);

        // R10 / R11: two storages behind one address
        acc_read(8'hA0, 1'b0, 8'h33, "R11 direct read via bus");
        acc_read(8'hA0, 1'b1, 8'hC4, "R10 indirect read of RAM");
        acc_read(8'hB5, 1'b0, 8'hB5 ^ 8'h5C, "R11 untouched register");

        // R5: read data holds while idle
        acc_read(8'h10, 1'b0, 8'hA5, "R5 latency");
        idle(); idle(); idle(); #1;
        check("R5 hold", rdata, 8'hA5);

        // R6 / R7: push and pop
        push(8'h11, 1'b0); #1;
        check("R6 sp after push", sp_value, 8'h08);
        push(8'h22, 1'b0); #1;
        check("R6 sp after second push", sp_value, 8'h09);
        pop("R7 pop last");
        #1;
        check("R7 sp after pop", sp_value, 8'h08);
        push(8'h77, 1'b1); #1;
        check("R6 push wins over pop", sp_value, 8'h09);
        pop("R6 pushed byte under pop");
        pop("R7 first byte");
        #1;
        check("R7 sp back", sp_value, 8'h07);

        // R9: stack climbs through upper RAM without bus traffic
        w0 = sfr_wr_cnt;
        r0 = sfr_rd_cnt;
        for (int i = 8; i < 256; i++) push(8'(i) ^ 8'hC3, 1'b0);
        #1;
        check("R9 sp at top", sp_value, 8'hFF);
        check_int("R9 no bus writes", sfr_wr_cnt, w0);
        acc_read(8'h90, 1'b0, 8'h90 ^ 8'h5C, "R9 register at 90H intact");
        acc_read(8'h90, 1'b1, 8'h90 ^ 8'hC3, "R9 stack byte in upper RAM");

        // R8: wrap in both directions
        push(8'hE1, 1'b0); #1;
        check("R8 push wraps", sp_value, 8'h00);
        pop("R8 pop at 00H");
        #1;
        check("R8 pop wraps", sp_value, 8'hFF);
        pop("R9 pop from upper RAM");
        idle(); #1;
        check_int("R9 no bus reads", sfr_rd_cnt, r0 + 1);
        acc_read(8'h00, 1'b0, 8'hE1, "R8 wrapped push stored at 00H");
        idle(); idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule